// File: doc/BRIEF.md
# Folded SHA-256 Compression Round Engine

This block runs the SHA-256 compression rounds over one 512-bit message block, starting from a 256-bit chaining state. The round hardware is split into `NUM_ROUNDS/LOOP` physical stages. A block travels through these stages once per pass and makes `LOOP` passes, so the design trades area against latency with one parameter. A pass counter and a stage pointer track which round each stage is working on. The constant for the next round is read one cycle early from a registered, synchronously read 64-word table into the register of the stage that will use it.

The round count can be set below 64, for example to 61, when only some of the result words are needed. Padding, nonce stepping and the final addition of the chaining value are left to the surrounding logic. The block takes one message block at a time. It raises `ready` when it can accept the next one and pulses `done` when the result is present on `digest`.

Top module: `sha256_fold_core`

## Requirements
- R1: After reset, `ready` is 1, `done` is 0 and `digest` is all zeros.
- R2: A start is accepted when `start` and `ready` are both high at a clock edge. From the next cycle `ready` stays low until the cycle in which `done` is high.
- R3: `done` is high for exactly one cycle, `NUM_ROUNDS` clock edges after the edge that accepted the start. In that cycle `ready` is high again.
- R4: `digest` holds the eight working words a..h after `NUM_ROUNDS` rounds. Word a is in bits 255:224 and word h is in bits 31:0. `chain_in` uses the same order. Message word 0 is `block_in[511:480]`. With the standard initial hash value and the padded message "abc", adding the chaining value word by word to `digest` gives ba7816bf 8f01cfea 414140de 5dae2223 b00361a3 96177a9c b410ff61 f20015ad.
- R5: `digest` changes only in a cycle where `done` is high. Otherwise it keeps its value.
- R6: `start`, `chain_in` and `block_in` have no effect while `ready` is low. The running block ends at the same time with the same result.
- R7: With `NUM_ROUNDS` = 64, the values `LOOP` = 1, 2, 4 and 64 give identical digests for any input.
- R8: With `NUM_ROUNDS` = 61, `digest` is the working state after only the first 61 rounds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a block |
| chain_in | input | 256 | Initial working state, a in the top word |
| block_in | input | 512 | Message block, word 0 in the top word |
| ready | output | 1 | Engine idle, start will be taken |
| done | output | 1 | One-cycle pulse, digest just updated |
| digest | output | 256 | Working state after the last round |

## Verification
The bench runs five configurations side by side, including the extreme fold with a single stage and the shortened 61-round variant. It compares each one against an arithmetic round model over the "abc" vector, all-zero, all-one and pseudo-random blocks. A design whose lookahead constant index is wrong at the wrap from the last stage back to stage 0 would still pass with `LOOP` = 1 but give a different digest for the folded variants. An early or late `done`, or a reloaded state from a start raised mid-block, shows up as a changed latency or as a digest that belongs to the injected block. A digest that is not held after `done` fails the check made several cycles later.

// File: rtl/sha256_fold_core.sv
module sha256_fold_core #(
  parameter int NUM_ROUNDS = 64,
  parameter int LOOP       = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [255:0] chain_in,
  input  logic [511:0] block_in,
  output logic         ready,
  output logic         done,
  output logic [255:0] digest
);
  localparam int STAGES = NUM_ROUNDS / LOOP;
  localparam int SW = (STAGES > 1) ? $clog2(STAGES) : 1;
  localparam int CW = (LOOP > 1) ? $clog2(LOOP) : 1;

  localparam logic [0:63][31:0] KTAB = {
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] round_step(input logic [255:0] s, input logic [31:0] k, input logic [31:0] w);
    logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
    {a, b, c, d, e, f, g, h} = s;
    t1 = h + (rotr(e, 6) ^ rotr(e, 11) ^ rotr(e, 25)) + ((e & f) ^ (~e & g)) + k + w;
    t2 = (rotr(a, 2) ^ rotr(a, 13) ^ rotr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
    return {t1 + t2, a, b, c, d + t1, e, f, g};
  endfunction

  logic          busy;
  logic [CW-1:0] cnt;
  logic [SW-1:0] stg;
  logic          take, last;
  logic [5:0]    kidx;
  logic [31:0]   w [16];
  logic [31:0]   wnew;
  logic [255:0]  rout [STAGES];

  assign ready = ~busy;
  assign take  = start & ~busy;
  assign last  = (stg == SW'(STAGES - 1)) && (cnt == CW'(LOOP - 1));
  assign kidx  = 6'(STAGES * int'(cnt) + int'(stg) + 1);
  assign wnew  = (rotr(w[14], 17) ^ rotr(w[14], 19) ^ (w[14] >> 10)) + w[9]
               + (rotr(w[1], 7) ^ rotr(w[1], 18) ^ (w[1] >> 3)) + w[0];

  for (genvar j = 0; j < STAGES; j++) begin : g_stage
    localparam int PREV = (j == 0) ? STAGES - 1 : j - 1;
    logic [255:0] sreg;
    logic [31:0]  kreg;
    always_ff @(posedge clk) begin
      if (take && j == 0) begin
        sreg <= chain_in;
        kreg <= KTAB[0];
      end else if (busy && !last && stg == SW'(PREV)) begin
        sreg <= rout[PREV];
        kreg <= KTAB[kidx];
      end
    end
    assign rout[j] = round_step(sreg, kreg, w[0]);
  end

  always_ff @(posedge clk) begin
    if (take) begin
      for (int k = 0; k < 16; k++) w[k] <= block_in[511 - 32*k -: 32];
    end else if (busy) begin
      for (int k = 0; k < 15; k++) w[k] <= w[k+1];
      w[15] <= wnew;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      stg    <= '0;
      done   <= 1'b0;
      digest <= '0;
    end else begin
      done <= 1'b0;
      if (take) begin
        busy <= 1'b1;
        cnt  <= '0;
        stg  <= '0;
      end else if (busy) begin
        if (last) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          digest <= rout[STAGES-1];
          cnt    <= '0;
          stg    <= '0;
        end else if (stg == SW'(STAGES - 1)) begin
          stg <= '0;
          cnt <= cnt + 1'b1;
        end else begin
          stg <= stg + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sha256_fold_core_chk.sv
module sha256_fold_core_chk #(
  parameter int NUM_ROUNDS = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         ready,
  input logic         done,
  input logic [255:0] digest
);
  logic [7:0] lat;

  always_ff @(posedge clk) begin
    if (!rst_n) lat <= '0;
    else if (start && ready) lat <= 8'd1;
    else if (done) lat <= '0;
    else if (lat != 0) lat <= lat + 8'd1;
  end

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);

  // R2
  ready_rise_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> done);

  // R3
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == 8'(NUM_ROUNDS + 1)) && ready);

  // R3
  no_missed_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat == 8'(NUM_ROUNDS + 1)) |-> done);

  // R5
  digest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(digest) |-> done);
endmodule

bind sha256_fold_core sha256_fold_core_chk #(.NUM_ROUNDS(NUM_ROUNDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .done(done), .digest(digest)
);

// File: tb/sha256_fold_core_bench.sv
module sha256_fold_core_bench;
  localparam int N = 5;
  localparam int NR [N] = '{64, 64, 64, 64, 61};
  localparam logic [255:0] IV = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                 32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
  localparam logic [255:0] ABC_HASH = {32'hba7816bf, 32'h8f01cfea, 32'h414140de, 32'h5dae2223,
                                       32'hb00361a3, 32'h96177a9c, 32'hb410ff61, 32'hf20015ad};
  localparam logic [511:0] ABC_BLK = {32'h61626380, {14{32'h0}}, 32'h00000018};
  localparam logic [0:63][31:0] KB = {
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [255:0] chain_in = '0;
  logic [511:0] block_in = '0;
  logic         rd [N];
  logic         dn [N];
  logic [255:0] dg [N];
  int checks = 0, errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  sha256_fold_core #(.NUM_ROUNDS(64), .LOOP(1)) u_sha256_fold_core (
    .clk(clk), .rst_n(rst_n), .start(start), .chain_in(chain_in), .block_in(block_in),
    .ready(rd[0]), .done(dn[0]), .digest(dg[0]));
  sha256_fold_core #(.NUM_ROUNDS(64), .LOOP(2)) u_sha256_fold_core_l2 (
    .clk(clk), .rst_n(rst_n), .start(start), .chain_in(chain_in), .block_in(block_in),
    .ready(rd[1]), .done(dn[1]), .digest(dg[1]));
  sha256_fold_core #(.NUM_ROUNDS(64), .LOOP(4)) u_sha256_fold_core_l4 (
    .clk(clk), .rst_n(rst_n), .start(start), .chain_in(chain_in), .block_in(block_in),
    .ready(rd[2]), .done(dn[2]), .digest(dg[2]));
  sha256_fold_core #(.NUM_ROUNDS(64), .LOOP(64)) u_sha256_fold_core_l64 (
    .clk(clk), .rst_n(rst_n), .start(start), .chain_in(chain_in), .block_in(block_in),
    .ready(rd[3]), .done(dn[3]), .digest(dg[3]));
  sha256_fold_core #(.NUM_ROUNDS(61), .LOOP(1)) u_sha256_fold_core_r61 (
    .clk(clk), .rst_n(rst_n), .start(start), .chain_in(chain_in), .block_in(block_in),
    .ready(rd[4]), .done(dn[4]), .digest(dg[4]));

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] ref_comp(input logic [255:0] st, input logic [511:0] blk, input int n);
    logic [31:0] ww [64];
    logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
    for (int t = 0; t < 16; t++) ww[t] = blk[511 - 32*t -: 32];
    for (int t = 16; t < 64; t++)
      ww[t] = (rr(ww[t-2], 17) ^ rr(ww[t-2], 19) ^ (ww[t-2] >> 10)) + ww[t-7]
            + (rr(ww[t-15], 7) ^ rr(ww[t-15], 18) ^ (ww[t-15] >> 3)) + ww[t-16];
    {a, b, c, d, e, f, g, h} = st;
    for (int t = 0; t < n; t++) begin
      t1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + KB[t] + ww[t];
      t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
      h = g; g = f; f = e; e = d + t1; d = c; c = b; b = a; a = t1 + t2;
    end
    return {a, b, c, d, e, f, g, h};
  endfunction

  function automatic logic [255:0] add_words(input logic [255:0] x, input logic [255:0] y);
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[32*k +: 32] = x[32*k +: 32] + y[32*k +: 32];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic next_word(output logic [31:0] v);
    seed = seed * 32'd1664525 + 32'd1013904223;
    v = seed ^ (seed >> 13);
  endtask

  task automatic run_block(input logic [255:0] c, input logic [511:0] b, input bit inject, input bit kat);
    logic [255:0] exp [N];
    logic [255:0] at_done [N];
    int seen [N];
    int ndone [N];
    bit early [N];
    for (int i = 0; i < N; i++) begin
      exp[i] = ref_comp(c, b, NR[i]);
      seen[i] = 0; ndone[i] = 0; early[i] = 1'b0; at_done[i] = '0;
    end
    chain_in = c; block_in = b; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < N; i++) chk(rd[i] == 1'b0, "R2", 256'(rd[i]), 256'(0));
    for (int k = 1; k <= 72; k++) begin
      @(posedge clk); @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (dn[i]) begin
          ndone[i]++;
          if (seen[i] == 0) begin seen[i] = k; at_done[i] = dg[i]; end
        end else if (rd[i] && seen[i] == 0) early[i] = 1'b1;
      end
      if (inject && k == 10) begin start = 1'b1; chain_in = ~c; block_in = ~b; end
      if (inject && k == 11) start = 1'b0;
    end
    for (int i = 0; i < N; i++) begin
      chk(!early[i], "R2", 256'(early[i]), 256'(0));
      chk(seen[i] == NR[i], "R3", 256'(seen[i]), 256'(NR[i]));
      chk(ndone[i] == 1, "R3", 256'(ndone[i]), 256'(1));
      chk(at_done[i] == exp[i], (i == 4) ? "R8" : ((i == 0) ? "R4" : "R7"), at_done[i], exp[i]);
      chk(dg[i] == exp[i], inject ? "R6" : "R5", dg[i], exp[i]);
      chk(rd[i] == 1'b1, "R3", 256'(rd[i]), 256'(1));
    end
    for (int i = 0; i < 4; i++) chk(dg[i] == dg[0], "R7", dg[i], dg[0]);
    if (kat)
      for (int i = 0; i < 4; i++) chk(add_words(dg[i], c) == ABC_HASH, "R4", add_words(dg[i], c), ABC_HASH);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] c;
    logic [511:0] b;
    logic [31:0]  v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      chk(rd[i] == 1'b1, "R1", 256'(rd[i]), 256'(1));
      chk(dn[i] == 1'b0, "R1", 256'(dn[i]), 256'(0));
      chk(dg[i] == '0, "R1", dg[i], '0);
    end
    run_block(IV, ABC_BLK, 1'b0, 1'b1);
    run_block('0, '0, 1'b0, 1'b0);
    run_block('1, '1, 1'b0, 1'b0);
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < 8; k++) begin next_word(v); c[32*k +: 32] = v; end
      for (int k = 0; k < 16; k++) begin next_word(v); b[32*k +: 32] = v; end
      run_block(c, b, (r % 2) == 1, 1'b0);
    end
    run_block(IV, ABC_BLK, 1'b1, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule